// File: doc/BRIEF.md
# Clock control register bank with PLL lock tracking

This block is a bank of 32-bit clock-control words behind a simple word-addressed bus. It holds clock enable masks, a source select, dividers, peripheral reset bits and four PLL control words. It does not generate or gate any clock. Every stored word is driven out on a flat image port so that neighbouring logic can use it directly. Accesses are single-cycle strobes. Read data and the error flag are registered and appear on the cycle after the strobe.

Each PLL word keeps two status bits that the bank maintains itself. One is a lock flag that the bank forces from the power-down request bit. The other is a sticky loss-of-lock flag: a power-down request sets it, and software clears it by writing 1 to it. The bank also follows fixed access rules. The software-reset word can only be written and never holds data. The identification word can only be read. Offsets beyond the last word, and offsets not on a 4-byte boundary, are rejected safely and flagged on a one-cycle error output.

Top module: `ccr_bank`

## Requirements
- R1: On cold reset (rst_n low) the words at byte offsets 0x00, 0x28 and 0x30 load 0xFFFFFFFF, 0x04 loads 0x004AAAAA and 0x08 loads 0x5413F855. The PLL words load 0x80222101 (0x0C), 0x80202101 (0x10), 0x80C02105 (0x54) and 0x81228606 (0x60). The identification word at 0x6C shows ID_VALUE (default 0x5A170C01), and every other word loads 0. bus_rdata and bus_err reset to 0.
- R2: A legal write to an ordinary word stores all 32 bits. A read returns the word on bus_rdata one clock edge after the strobe. A read and a write to the same word in one cycle return the old value. bus_rdata holds its value while no read is issued.
- R3: A write to a PLL word (0x0C, 0x10, 0x54, 0x60) with bit 12 (power-down) set stores the written value with bit 31 (lock) cleared and bit 30 (loss of lock) set.
- R4: A write to a PLL word with bit 12 clear stores the written value with bit 31 forced to 1.
- R5: When bit 12 is clear in a PLL write, writing 1 to bit 30 clears the stored loss-of-lock bit, and writing 0 leaves it unchanged.
- R6: The software-reset word at 0x14 accepts writes without error, but the stored value is always 0. Reads of it return 0.
- R7: The identification word at 0x6C reads ID_VALUE. A write to it changes nothing and raises the error.
- R8: At offsets from 0x70 to the end of the 4 KiB window, reads return 0 and writes change no word. Both raise the error.
- R9: An access whose address bits [1:0] are not 00 is illegal. Such a read returns 0, such a write changes no word, and both raise the error.
- R10: bus_err is high for exactly the one cycle after an illegal access (R7 write, R8, R9) and low after every legal or idle cycle.
- R11: reg_image carries word i at bits [32i+31:32i]. A write appears there one clock edge after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| bus_addr | input | ADDR_W (12) | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| bus_err | output | 1 | One-cycle illegal-access flag |
| reg_image | output | NREG*DATA_W (896) | All stored words, word i at [32i+31:32i] |

## Verification
The PLL words are exercised with power-down writes that also try to set the lock bit, then with normal-mode writes that carry 0 or 1 in the loss-of-lock position. This separates the forced lock bit from the sticky flag and shows whether a 0 wrongly clears the flag. Ordinary words receive all-ones, all-zeros and alternating patterns, plus a read and a write to the same word in one cycle, which exposes any read-after-write bypass. Illegal accesses are aimed at the identification word, just past the last word, at the top of the window and at misaligned offsets. The bench then checks that the image stays unchanged and that the error flag drops on the next legal or idle cycle.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned PD_BIT   = 12;
   localparam int unsigned LOCK_BIT = 31;
   localparam int unsigned LOSS_BIT = 30;
   localparam int unsigned IX_SWRST = 5;

   typedef enum logic [1:0] {
      WK_PLAIN,
      WK_PLL,
      WK_WONLY,
      WK_RONLY
   } word_kind_e;

   // Access behaviour of word ix; the last word of the bank is the read-only identifier.
   function automatic word_kind_e kind_of(input int unsigned ix, input int unsigned nreg);
      if (ix == nreg - 1) return WK_RONLY;
      case (ix)
         3, 4, 21, 24: return WK_PLL;
         IX_SWRST:     return WK_WONLY;
         default:      return WK_PLAIN;
      endcase
   endfunction

   // Cold reset contents; PLL words come up reporting lock.
   function automatic logic [WORD_W-1:0] cold_value(input int unsigned ix);
      logic [WORD_W-1:0] lk;
      lk = 32'h8000_0000;
      case (ix)
         0, 10, 12: return 32'hFFFF_FFFF;
         1:         return 32'h004A_AAAA;
         2:         return 32'h5413_F855;
         3:         return lk | 32'h0022_2101;
         4:         return lk | 32'h0020_2101;
         21:        return lk | 32'h00C0_2105;
         24:        return lk | 32'h0122_8606;
         default:   return '0;
      endcase
   endfunction

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned NREG   = 28,
   parameter int unsigned IDX_W  = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic              hit
);
   localparam int unsigned WIX_W = ADDR_W - 2;

   logic [WIX_W-1:0] wix;
   logic             aligned;
   logic             in_range;

   assign wix      = addr[ADDR_W-1:2];
   assign aligned  = (addr[1:0] == 2'b00);
   assign in_range = (32'(wix) < 32'(NREG));
   assign idx      = wix[IDX_W-1:0];
   assign hit      = aligned & in_range;

endmodule

// File: rtl/ccr_pll_merge.sv
module ccr_pll_merge
   import ccr_pkg::*;
(
   input  logic [WORD_W-1:0] wdata,
   input  logic [WORD_W-1:0] cur,
   output logic [WORD_W-1:0] nxt
);
   logic unused_cur;
   assign unused_cur = ^{cur[LOCK_BIT], cur[LOSS_BIT-1:0]};

   always_comb begin
      nxt = wdata;
      if (wdata[PD_BIT]) begin
         nxt[LOCK_BIT] = 1'b0;
         nxt[LOSS_BIT] = 1'b1;
      end else begin
         nxt[LOCK_BIT] = 1'b1;
         nxt[LOSS_BIT] = cur[LOSS_BIT] & ~wdata[LOSS_BIT];
      end
   end

endmodule

// File: rtl/ccr_word.sv
module ccr_word
   import ccr_pkg::*;
#(
   parameter word_kind_e        KIND    = WK_PLAIN,
   parameter logic [WORD_W-1:0] RST_VAL = '0,
   parameter logic [WORD_W-1:0] FIXED   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] q
);
   generate
      if (KIND == WK_RONLY) begin : g_ro
         logic unused_ro;
         assign unused_ro = ^{clk, rst_n, we, wdata, RST_VAL};
         assign q = FIXED;
      end else if (KIND == WK_WONLY) begin : g_wo
         logic unused_wo;
         assign unused_wo = ^{wdata, RST_VAL, FIXED};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= '0;
            else if (we) q <= '0;
         end
      end else if (KIND == WK_PLL) begin : g_pll
         logic [WORD_W-1:0] nxt;
         logic              unused_pll;
         assign unused_pll = ^FIXED;
         ccr_pll_merge u_merge (
            .wdata (wdata),
            .cur   (q),
            .nxt   (nxt)
         );
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= RST_VAL;
            else if (we) q <= nxt;
         end
      end else begin : g_plain
         logic unused_pl;
         assign unused_pl = ^FIXED;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= RST_VAL;
            else if (we) q <= wdata;
         end
      end
   endgenerate

endmodule

// File: rtl/ccr_bank.sv
module ccr_bank
   import ccr_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 12,
   parameter int unsigned       NREG     = 28,
   parameter int unsigned       DATA_W   = 32,
   parameter logic [DATA_W-1:0] ID_VALUE = 32'h5A17_0C01
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   output logic                     bus_err,
   output logic [NREG*DATA_W-1:0]   reg_image
);
   localparam int unsigned IDX_W = $clog2(NREG);
   localparam int unsigned IX_ID = NREG - 1;

   generate
      if (DATA_W != WORD_W) begin : g_bad_width
         $error("ccr_bank: DATA_W must equal %0d", WORD_W);
      end
      if (NREG < 26) begin : g_bad_nreg
         $error("ccr_bank: NREG must leave room for all PLL words and the identifier");
      end
      if (NREG * 4 > (1 << ADDR_W)) begin : g_bad_addr
         $error("ccr_bank: bank does not fit in the address window");
      end
   endgenerate

   logic [IDX_W-1:0]  idx;
   logic              hit;
   logic [NREG-1:0]   we;
   logic [DATA_W-1:0] q [NREG];
   logic [DATA_W-1:0] rd_word;
   logic              bad_rd;
   logic              bad_wr;

   ccr_decode #(
      .ADDR_W (ADDR_W),
      .NREG   (NREG),
      .IDX_W  (IDX_W)
   ) u_decode (
      .addr (bus_addr),
      .idx  (idx),
      .hit  (hit)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NREG; gi++) begin : g_word
         assign we[gi] = bus_wr & hit & (idx == IDX_W'(gi));
         ccr_word #(
            .KIND    (kind_of(gi, NREG)),
            .RST_VAL (cold_value(gi)),
            .FIXED   (ID_VALUE)
         ) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we[gi]),
            .wdata (bus_wdata),
            .q     (q[gi])
         );
         assign reg_image[gi*DATA_W +: DATA_W] = q[gi];
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NREG; i++) begin
         if (hit && idx == IDX_W'(i)) rd_word = q[i];
      end
   end

   assign bad_rd = bus_rd & ~hit;
   assign bad_wr = bus_wr & (~hit | (idx == IDX_W'(IX_ID)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         if (bus_rd) bus_rdata <= rd_word;
         bus_err <= bad_rd | bad_wr;
      end
   end

endmodule

// File: rtl/ccr_bank_chk.sv
module ccr_bank_chk #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned NREG   = 28,
   parameter int unsigned DATA_W = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic                   bus_wr,
   input logic                   bus_rd,
   input logic [DATA_W-1:0]      bus_wdata,
   input logic [DATA_W-1:0]      bus_rdata,
   input logic                   bus_err,
   input logic [NREG*DATA_W-1:0] reg_image
);
   localparam logic [ADDR_W-1:0] A_PLL0  = ADDR_W'(12);
   localparam logic [ADDR_W-1:0] A_SWRST = ADDR_W'(20);
   localparam int unsigned       P_LOCK  = 3*DATA_W + 31;
   localparam int unsigned       P_LOSS  = 3*DATA_W + 30;

   logic misal, beyond, ro_hit, bad;
   assign misal  = |bus_addr[1:0];
   assign beyond = 32'(bus_addr[ADDR_W-1:2]) >= 32'(NREG);
   assign ro_hit = 32'(bus_addr[ADDR_W-1:2]) == 32'(NREG - 1);
   assign bad    = (bus_rd & (misal | beyond)) | (bus_wr & (misal | beyond | ro_hit));

   a_r3_pd_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_PLL0 && bus_wdata[12]) |=> (!reg_image[P_LOCK] && reg_image[P_LOSS]));

   a_r4_lock_forced: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_PLL0 && !bus_wdata[12]) |=> reg_image[P_LOCK]);

   a_r5_loss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_PLL0 && !bus_wdata[12] && !bus_wdata[30])
      |=> (reg_image[P_LOSS] == $past(reg_image[P_LOSS])));

   a_r6_swrst_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_SWRST) |=> (bus_rdata == '0));

   a_r8_beyond_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && beyond) |=> $stable(reg_image));

   a_r9_misaligned_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && misal) |=> $stable(reg_image));

   a_r10_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
      bad |=> bus_err);

   a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !bad |=> !bus_err);

endmodule

bind ccr_bank ccr_bank_chk #(
   .ADDR_W (ADDR_W),
   .NREG   (NREG),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .bus_err   (bus_err),
   .reg_image (reg_image)
);

// File: tb/tb_ccr_bank.sv
`timescale 1ns/1ps
module tb_ccr_bank;
   localparam int          NREG = 28;
   localparam logic [31:0] IDV  = 32'h5A17_0C01;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [11:0]      bus_addr;
   logic             bus_wr;
   logic             bus_rd;
   logic [31:0]      bus_wdata;
   logic [31:0]      bus_rdata;
   logic             bus_err;
   logic [NREG*32-1:0] reg_image;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [31:0] m [NREG];
   logic [31:0] m_rdata;
   logic        m_err;

   always #5 clk = ~clk;

   ccr_bank dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_err   (bus_err),
      .reg_image (reg_image)
   );

   // R1 expected cold contents
   task automatic model_reset();
      for (int i = 0; i < NREG; i++) m[i] = 32'h0;
      m[0]  = 32'hFFFF_FFFF;
      m[10] = 32'hFFFF_FFFF;
      m[12] = 32'hFFFF_FFFF;
      m[1]  = 32'h004A_AAAA;
      m[2]  = 32'h5413_F855;
      m[3]  = 32'h8022_2101;
      m[4]  = 32'h8020_2101;
      m[21] = 32'h80C0_2105;
      m[24] = 32'h8122_8606;
      m[27] = IDV;
      m_rdata = 32'h0;
      m_err   = 1'b0;
   endtask

   function automatic bit is_pll(input int ix);
      return (ix == 3) || (ix == 4) || (ix == 21) || (ix == 24);
   endfunction

   task automatic model_edge(input logic wr, input logic rd, input logic [11:0] a, input logic [31:0] d);
      int ix;
      bit ok;
      logic [31:0] v;
      ix = int'(a[11:2]);
      ok = (a[1:0] == 2'b00) && (ix < NREG);
      m_err = 1'b0;
      if (rd) begin
         if (!ok) begin m_rdata = 32'h0; m_err = 1'b1; end
         else if (ix == 5) m_rdata = 32'h0;
         else if (ix == NREG - 1) m_rdata = IDV;
         else m_rdata = m[ix];
      end
      if (wr) begin
         if (!ok || ix == NREG - 1) m_err = 1'b1;
         else if (ix == 5) m[ix] = 32'h0;
         else if (is_pll(ix)) begin
            v = d;
            if (d[12]) begin v[31] = 1'b0; v[30] = 1'b1; end
            else begin v[31] = 1'b1; v[30] = d[30] ? 1'b0 : m[ix][30]; end
            m[ix] = v;
         end else m[ix] = d;
      end
   endtask

   task automatic compare(input string tag);
      bit bad;
      checks++;
      if (bus_rdata !== m_rdata) begin
         errors++;
         $display("FAIL %s rdata act=%h exp=%h", tag, bus_rdata, m_rdata);
      end
      checks++;
      if (bus_err !== m_err) begin
         errors++;
         $display("FAIL %s/R10 err act=%b exp=%b", tag, bus_err, m_err);
      end
      checks++;
      bad = 0;
      for (int i = 0; i < NREG; i++) begin
         if (!bad && reg_image[i*32 +: 32] !== m[i]) begin
            bad = 1;
            $display("FAIL %s/R11 image word %0d act=%h exp=%h", tag, i, reg_image[i*32 +: 32], m[i]);
         end
      end
      if (bad) errors++;
   endtask

   task automatic step(input logic wr, input logic rd, input logic [11:0] a, input logic [31:0] d, input string tag);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      model_edge(wr, rd, a, d);
      @(negedge clk);
      compare(tag);
      bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
      step(1'b1, 1'b0, a, d, tag);
   endtask

   task automatic rd(input logic [11:0] a, input string tag);
      step(1'b0, 1'b1, a, 32'h0, tag);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired act=running exp=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [11:0] plls [4];
      plls[0] = 12'h00C; plls[1] = 12'h010; plls[2] = 12'h054; plls[3] = 12'h060;
      rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      compare("R1");
      for (int i = 0; i < NREG; i++) rd(12'(i*4), "R1");

      // R2 ordinary words
      wr(12'h008, 32'hA5A5_A5A5, "R2"); rd(12'h008, "R2");
      wr(12'h040, 32'hFFFF_FFFF, "R2"); rd(12'h040, "R2");
      wr(12'h040, 32'h0000_0000, "R2"); rd(12'h040, "R2");
      wr(12'h018, 32'h5A5A_5A5A, "R2");
      step(1'b1, 1'b1, 12'h040, 32'h1234_5678, "R2");
      rd(12'h040, "R2");
      step(1'b0, 1'b0, 12'h000, 32'h0, "R2");

      // R3 / R4 / R5 PLL words
      foreach (plls[k]) begin
         wr(plls[k], 32'h8000_1F0F, "R3"); rd(plls[k], "R3");
         wr(plls[k], 32'h0000_0A5A, "R4"); rd(plls[k], "R4");
         wr(plls[k], 32'h4000_0A5A, "R5"); rd(plls[k], "R5");
         wr(plls[k], 32'h0000_1001, "R3");
         wr(plls[k], 32'h0000_0001, "R5"); rd(plls[k], "R5");
         wr(plls[k], 32'h4000_0001, "R5");
         wr(plls[k], 32'h0000_0000, "R5"); rd(plls[k], "R5");
      end

      // R6 write-only software reset word
      wr(12'h014, 32'hFFFF_FFFF, "R6"); rd(12'h014, "R6");

      // R7 read-only identifier
      rd(12'h06C, "R7"); wr(12'h06C, 32'h0000_0000, "R7"); rd(12'h06C, "R7");

      // R8 beyond the last word
      wr(12'h070, 32'hDEAD_BEEF, "R8"); rd(12'h070, "R8");
      wr(12'hFFC, 32'hCAFE_F00D, "R8"); rd(12'hFFC, "R8");
      step(1'b1, 1'b1, 12'h800, 32'h1111_2222, "R8");

      // R9 misaligned
      wr(12'h009, 32'h1111_1111, "R9"); rd(12'h00A, "R9");
      wr(12'h043, 32'h7777_7777, "R9"); rd(12'h040, "R9");

      // R10 error drops after one cycle
      rd(12'h0F0, "R10");
      step(1'b0, 1'b0, 12'h000, 32'h0, "R10");
      wr(12'h06C, 32'h1, "R10");
      rd(12'h000, "R10");

      // R11 final sweep
      for (int i = 0; i < NREG; i++) rd(12'(i*4), "R11");

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule